// File: doc/BRIEF.md
# Adjustable Sample-Point Asynchronous Serial Receiver

This block receives frames from one asynchronous serial line. A frame opens with a falling edge on the idle-high line. The receiver then samples every bit cell once. The sample instant sits at a programmable fraction of the cell rather than at its centre, which lets a system tune for slow edges or for line distortion. At run time the integrator chooses the word width, the bit order, the parity treatment, the number of clock cycles per bit and the sample percentage. An inversion input complements the line ahead of all edge detection and sampling, so inverted links need no extra logic.

Each completed frame produces a one-cycle strobe. The strobe comes with the received word and a flag telling whether the frame was clean. Separate one-cycle pulses report a bad start bit, a parity mismatch and a low stop bit.

The controller has five named states:
- `S_IDLE` waits for a falling edge (edge → `S_START`).
- `S_START` samples the start bit (low → `S_DATA`, high → `S_IDLE` with a start error).
- `S_DATA` collects the word (last bit → `S_PARITY` when a parity slot exists, otherwise → `S_STOP`).
- `S_PARITY` samples the parity slot (→ `S_STOP`).
- `S_STOP` samples the stop bit, delivers the frame and returns at once to `S_IDLE`.

Top module: `uart_sp_rx`

## Requirements
- R1: After reset, `frame_valid_o`, `frame_good_o`, `start_err_o`, `parity_err_o`, `stop_err_o` and `frame_data_o` are all 0.
- R2: A frame starts at the first cycle F in which the (possibly inverted) line is seen low after being high. Bit slot n is sampled in cycle F + K + n·C. C is the number of cycles per bit and must be at least 2. K = ceil((C−1)·P/100) in integer arithmetic, where P is the effective percentage. Slot 0 is the start bit, slots 1..W are data, then comes the parity slot (when one is used), then the stop bit.
- R3: A sample percentage of 0 or above 99 is replaced by 50. Values 1..99 are used as given.
- R4: The word width `cfg_width_i` selects 5 to 9 data bits. Values below 5 act as 5 and values above 9 act as 9. Unused high bits of `frame_data_o` read 0.
- R5: With `cfg_msb_first_i`=0 the first data bit received lands in bit 0 of the word. With 1, the first data bit lands in bit W−1.
- R6: The parity code `cfg_parity_i` is decoded as follows:
  - 0: no parity slot.
  - 1: odd, so data plus parity holds an odd number of ones.
  - 2: even.
  - 3: the parity bit must be 0.
  - 4: the parity bit must be 1.
  - 5: a parity slot is present but always accepted.
  - 6 and 7: behave like 0.
- R7: A parity mismatch pulses `parity_err_o` for one cycle at the parity sample. The stop bit is still sampled, and the frame is delivered with its data and `frame_good_o`=0.
- R8: A start bit seen high at its sample point pulses `start_err_o` and `frame_valid_o` together, with `frame_good_o`=0 and `frame_data_o`=0. The receiver then waits for a new falling edge.
- R9: A stop bit sampled low pulses `stop_err_o` in the same cycle as `frame_valid_o`, with `frame_good_o`=0, and the received data is still delivered.
- R10: With `rx_invert_i`=1 the line is complemented before edge detection and sampling, so a low idle level and a complemented frame decode the same word.
- R11: `frame_valid_o` is high for exactly one cycle, in the cycle after the stop sample. `frame_good_o` and `frame_data_o` change only together with it. A falling edge in the very next cycle after the stop sample starts a new frame.
- R12: Width, parity mode, bit order, cycles per bit and percentage are captured only while idle. Changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line_i | input | 1 | Serial line, synchronous to clk |
| rx_invert_i | input | 1 | Complement the line when 1 |
| cfg_width_i | input | 4 | Data bits per word (5..9) |
| cfg_parity_i | input | 3 | Parity mode code (see R6) |
| cfg_msb_first_i | input | 1 | Bit order: 1 = first bit is the most significant |
| cfg_sample_pct_i | input | 7 | Sample point as a percentage of the cell |
| cfg_bit_cycles_i | input | 16 | Clock cycles per bit cell (2 or more) |
| frame_valid_o | output | 1 | One-cycle strobe per delivered frame |
| frame_data_o | output | 9 | Received word, zero-extended |
| frame_good_o | output | 1 | Frame had no start, parity or stop fault |
| start_err_o | output | 1 | Start bit was high at its sample |
| parity_err_o | output | 1 | Parity slot failed its check |
| stop_err_o | output | 1 | Stop bit was low at its sample |

## Verification
Two events can land in the same cycle: delivery of a frame and a stop-bit fault. The bench sends a frame whose stop cell is low and expects the strobe, the stop-error pulse, the cleared good flag and the intact word all in one cycle.

The other tight spot is the end of one frame against the start of the next. The bench trims the stop cell to end one cycle after its sample point and starts the next frame immediately. It then expects two separate deliveries with the correct words. Sample-point placement is judged with cells that hold the intended level only in the single cycle predicted by R2, and the complement everywhere else.

// File: rtl/uart_sp_pkg.sv
package uart_sp_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_START  = 3'd1,
        S_DATA   = 3'd2,
        S_PARITY = 3'd3,
        S_STOP   = 3'd4
    } rx_state_t;

    localparam logic [2:0] PAR_ODD    = 3'd1;
    localparam logic [2:0] PAR_EVEN   = 3'd2;
    localparam logic [2:0] PAR_ZERO   = 3'd3;
    localparam logic [2:0] PAR_ONE    = 3'd4;
    localparam logic [2:0] PAR_IGNORE = 3'd5;

    localparam logic [6:0] PCT_DEFAULT = 7'd50;

    // Percentage outside 1..99 falls back to the cell middle.
    function automatic logic [6:0] eff_pct(input logic [6:0] p);
        return ((p == 7'd0) || (p > 7'd99)) ? PCT_DEFAULT : p;
    endfunction

    // Codes 1..5 reserve a parity slot; all others skip it.
    function automatic logic has_parity_slot(input logic [2:0] mode);
        return (mode >= PAR_ODD) && (mode <= PAR_IGNORE);
    endfunction

    // Accept test for the parity slot given the XOR of the data bits.
    function automatic logic parity_accept(input logic [2:0] mode,
                                           input logic pbit,
                                           input logic data_xor);
        logic ok;
        case (mode)
            PAR_ODD:  ok = (data_xor ^ pbit);
            PAR_EVEN: ok = ~(data_xor ^ pbit);
            PAR_ZERO: ok = ~pbit;
            PAR_ONE:  ok = pbit;
            default:  ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/uart_sp_timebase.sv
module uart_sp_timebase
    import uart_sp_pkg::*;
#(
    parameter int CYC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en_i,
    input  logic [CYC_W-1:0] bit_cycles_i,
    input  logic [6:0]       pct_i,
    input  logic             arm_i,
    output logic             tick_o
);
    localparam int PROD_W = CYC_W + 8;

    logic [CYC_W-1:0]  cyc_q;
    logic [CYC_W-1:0]  off_q;
    logic [CYC_W-1:0]  wait_q;
    logic [CYC_W-1:0]  cyc_m1;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] off_full;

    // ceil((C-1)*P/100) computed once per load, off the sampling path
    always_comb begin
        cyc_m1   = bit_cycles_i - CYC_W'(1);
        prod     = PROD_W'(cyc_m1) * PROD_W'(eff_pct(pct_i)) + PROD_W'(99);
        off_full = prod / PROD_W'(100);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= CYC_W'(2);
            off_q <= CYC_W'(1);
        end else if (load_en_i) begin
            cyc_q <= bit_cycles_i;
            off_q <= off_full[CYC_W-1:0];
        end
    end

    // Down-counter: reaching zero marks a sample instant.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               wait_q <= '1;
        else if (arm_i)           wait_q <= off_q - CYC_W'(1);
        else if (wait_q == '0)    wait_q <= cyc_q - CYC_W'(1);
        else                      wait_q <= wait_q - CYC_W'(1);
    end

    assign tick_o = (wait_q == '0);

endmodule

// File: rtl/uart_sp_assembler.sv
module uart_sp_assembler #(
    parameter int MAXW  = 9,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             shift_i,
    input  logic             bit_i,
    input  logic             msb_first_i,
    input  logic [IDX_W-1:0] width_i,
    output logic [MAXW-1:0]  word_o,
    output logic             last_o,
    output logic             xor_o
);
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] pos;
    logic [MAXW-1:0]  word_q;
    logic             xor_q;

    always_comb begin
        pos    = msb_first_i ? (width_i - IDX_W'(1) - idx_q) : idx_q;
        last_o = (idx_q == width_i - IDX_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            word_q <= '0;
            xor_q  <= 1'b0;
        end else if (clear_i) begin
            idx_q  <= '0;
            word_q <= '0;
            xor_q  <= 1'b0;
        end else if (shift_i) begin
            idx_q <= idx_q + IDX_W'(1);
            xor_q <= xor_q ^ bit_i;
            for (int b = 0; b < MAXW; b++) begin
                if (pos == IDX_W'(b)) word_q[b] <= bit_i;
            end
        end
    end

    assign word_o = word_q;
    assign xor_o  = xor_q;

endmodule

// File: rtl/uart_sp_rx.sv
module uart_sp_rx
    import uart_sp_pkg::*;
#(
    parameter int CYC_W    = 16,
    parameter int MAX_BITS = 9,
    parameter int MIN_BITS = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rx_line_i,
    input  logic                          rx_invert_i,
    input  logic [$clog2(MAX_BITS+1)-1:0] cfg_width_i,
    input  logic [2:0]                    cfg_parity_i,
    input  logic                          cfg_msb_first_i,
    input  logic [6:0]                    cfg_sample_pct_i,
    input  logic [CYC_W-1:0]              cfg_bit_cycles_i,
    output logic                          frame_valid_o,
    output logic [MAX_BITS-1:0]           frame_data_o,
    output logic                          frame_good_o,
    output logic                          start_err_o,
    output logic                          parity_err_o,
    output logic                          stop_err_o
);
    localparam int IDX_W = $clog2(MAX_BITS + 1);

    rx_state_t        state_q, state_d;
    logic             line_n, line_q, fall;
    logic             idle, tick, arm;
    logic [IDX_W-1:0] width_q, width_clamped;
    logic [2:0]       par_q;
    logic             msb_q, good_q;
    logic [MAX_BITS-1:0] word;
    logic             last_bit, data_xor;

    assign line_n = rx_line_i ^ rx_invert_i;
    assign idle   = (state_q == S_IDLE);
    assign fall   = line_q & ~line_n;
    assign arm    = idle & fall;

    always_comb begin
        if (cfg_width_i < IDX_W'(MIN_BITS))      width_clamped = IDX_W'(MIN_BITS);
        else if (cfg_width_i > IDX_W'(MAX_BITS)) width_clamped = IDX_W'(MAX_BITS);
        else                                     width_clamped = cfg_width_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q  <= 1'b1;
            width_q <= IDX_W'(MAX_BITS - 1);
            par_q   <= '0;
            msb_q   <= 1'b0;
        end else begin
            line_q <= line_n;
            if (idle) begin
                width_q <= width_clamped;
                par_q   <= cfg_parity_i;
                msb_q   <= cfg_msb_first_i;
            end
        end
    end

    uart_sp_timebase #(.CYC_W(CYC_W)) u_timebase (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_en_i    (idle),
        .bit_cycles_i (cfg_bit_cycles_i),
        .pct_i        (cfg_sample_pct_i),
        .arm_i        (arm),
        .tick_o       (tick)
    );

    uart_sp_assembler #(.MAXW(MAX_BITS), .IDX_W(IDX_W)) u_assembler (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (arm),
        .shift_i     ((state_q == S_DATA) && tick),
        .bit_i       (line_n),
        .msb_first_i (msb_q),
        .width_i     (width_q),
        .word_o      (word),
        .last_o      (last_bit),
        .xor_o       (data_xor)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (fall) state_d = S_START;
            S_START:  if (tick) state_d = line_n ? S_IDLE : S_DATA;
            S_DATA:   if (tick && last_bit)
                          state_d = has_parity_slot(par_q) ? S_PARITY : S_STOP;
            S_PARITY: if (tick) state_d = S_STOP;
            S_STOP:   if (tick) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_valid_o <= 1'b0;
            frame_data_o  <= '0;
            frame_good_o  <= 1'b0;
            start_err_o   <= 1'b0;
            parity_err_o  <= 1'b0;
            stop_err_o    <= 1'b0;
            good_q        <= 1'b1;
        end else begin
            frame_valid_o <= 1'b0;
            start_err_o   <= 1'b0;
            parity_err_o  <= 1'b0;
            stop_err_o    <= 1'b0;
            unique case (state_q)
                S_IDLE: if (fall) good_q <= 1'b1;
                S_START: if (tick && line_n) begin
                    frame_valid_o <= 1'b1;
                    frame_data_o  <= '0;
                    frame_good_o  <= 1'b0;
                    start_err_o   <= 1'b1;
                end
                S_DATA: ;
                S_PARITY: if (tick && !parity_accept(par_q, line_n, data_xor)) begin
                    parity_err_o <= 1'b1;
                    good_q       <= 1'b0;
                end
                S_STOP: if (tick) begin
                    frame_valid_o <= 1'b1;
                    frame_data_o  <= word;
                    frame_good_o  <= good_q & line_n;
                    stop_err_o    <= ~line_n;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/uart_sp_rx_checker.sv
module uart_sp_rx_checker (
    input logic clk,
    input logic rst_n,
    input logic frame_valid_o,
    input logic frame_good_o,
    input logic start_err_o,
    input logic parity_err_o,
    input logic stop_err_o
);
    p_strobe_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid_o |=> !frame_valid_o);

    p_good_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid_o |-> $stable(frame_good_o));

    p_start_err_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_err_o |-> (frame_valid_o && !frame_good_o && !stop_err_o));

    p_stop_err_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_err_o |-> (frame_valid_o && !frame_good_o));

    p_parity_before_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        parity_err_o |-> (!frame_valid_o && !start_err_o));

    p_parity_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        parity_err_o |=> !parity_err_o);
endmodule

bind uart_sp_rx uart_sp_rx_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_valid_o (frame_valid_o),
    .frame_good_o  (frame_good_o),
    .start_err_o   (start_err_o),
    .parity_err_o  (parity_err_o),
    .stop_err_o    (stop_err_o)
);

// File: tb/uart_sp_rx_test.sv
module uart_sp_rx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_line = 1'b1;
    logic        rx_inv = 1'b0;
    logic [3:0]  cfg_width = 4'd8;
    logic [2:0]  cfg_par = 3'd0;
    logic        cfg_msb = 1'b0;
    logic [6:0]  cfg_pct = 7'd50;
    logic [15:0] cfg_cyc = 16'd8;
    logic        fv, fg, se, pe, ste;
    logic [8:0]  fd;

    int errors = 0, checks = 0;
    int cap_cnt = 0, se_cnt = 0, pe_cnt = 0, ste_cnt = 0;
    logic [8:0] cap_data [0:7];
    logic       cap_good [0:7];

    always #2.5 clk = ~clk;

    uart_sp_rx uut (
        .clk(clk), .rst_n(rst_n), .rx_line_i(rx_line), .rx_invert_i(rx_inv),
        .cfg_width_i(cfg_width), .cfg_parity_i(cfg_par), .cfg_msb_first_i(cfg_msb),
        .cfg_sample_pct_i(cfg_pct), .cfg_bit_cycles_i(cfg_cyc),
        .frame_valid_o(fv), .frame_data_o(fd), .frame_good_o(fg),
        .start_err_o(se), .parity_err_o(pe), .stop_err_o(ste)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (fv) begin
                if (cap_cnt < 8) begin
                    cap_data[cap_cnt] = fd;
                    cap_good[cap_cnt] = fg;
                end
                cap_cnt++;
            end
            if (se)  se_cnt++;
            if (pe)  pe_cnt++;
            if (ste) ste_cnt++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_caps();
        cap_cnt = 0; se_cnt = 0; pe_cnt = 0; ste_cnt = 0;
    endtask

    function automatic int exp_off(input int cyc, input int pct);
        int p;
        p = (pct < 1 || pct > 99) ? 50 : pct;
        return ((cyc - 1) * p + 99) / 100;
    endfunction

    task automatic drive(input logic v);
        @(negedge clk);
        rx_line = v ^ rx_inv;
    endtask

    // Send one frame. pforce: -1 = computed parity, else forced value.
    task automatic send(input int nbits, input logic [8:0] val, input bit msb,
                        input int pmode, input int pforce, input bit stop_v,
                        input bit narrow, input int cyc, input int off,
                        input int stop_len, input int tail);
        logic slots [0:11];
        int   n;
        logic px;
        px = 1'b0;
        for (int i = 0; i < nbits; i++) px ^= val[i];
        slots[0] = 1'b0;
        n = 1;
        for (int i = 0; i < nbits; i++) begin
            slots[n] = msb ? val[nbits-1-i] : val[i];
            n++;
        end
        if (pmode >= 1 && pmode <= 5) begin
            case (pmode)
                1: slots[n] = ~px;
                2: slots[n] = px;
                4: slots[n] = 1'b1;
                default: slots[n] = 1'b0;
            endcase
            if (pforce >= 0) slots[n] = pforce[0];
            n++;
        end
        slots[n] = stop_v;
        for (int s = 0; s <= n; s++) begin
            int len;
            len = (s == n) ? stop_len : cyc;
            for (int j = 0; j < len; j++) begin
                logic v;
                v = slots[s];
                if (narrow && j != off) v = ~slots[s];
                if (s == 0 && j == 0) v = 1'b0;
                if (s == n && j > off) v = 1'b1;
                drive(v);
            end
        end
        for (int j = 0; j < tail; j++) drive(1'b1);
    endtask

    task automatic set_cfg(input int w, input int par, input bit msb,
                           input int pct, input int cyc);
        @(negedge clk);
        cfg_width = 4'(w); cfg_par = 3'(par); cfg_msb = msb;
        cfg_pct = 7'(pct); cfg_cyc = 16'(cyc);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 valid", int'(fv), 0);
        check("R1 good", int'(fg), 0);
        check("R1 data", int'(fd), 0);
        check("R1 errs", int'(se) + int'(pe) + int'(ste), 0);
    endtask

    task automatic t_basic();
        set_cfg(8, 0, 0, 50, 8);
        clear_caps();
        send(8, 9'h0A5, 0, 0, -1, 1, 0, 8, 4, 8, 4);
        check("R2 count", cap_cnt, 1);
        check("R2 data", int'(cap_data[0]), 'hA5);
        check("R2 good", int'(cap_good[0]), 1);
        check("R11 held data", int'(fd), 'hA5);
    endtask

    task automatic t_order();
        set_cfg(8, 0, 1, 50, 8);
        clear_caps();
        send(8, 9'h0C3 ^ 9'h011, 1, 0, -1, 1, 0, 8, 4, 8, 4);
        check("R5 msb-first data", int'(cap_data[0]), 'hD2);
        set_cfg(8, 0, 0, 50, 8);
        clear_caps();
        send(8, 9'h001, 0, 0, -1, 1, 0, 8, 4, 8, 4);
        check("R5 lsb-first data", int'(cap_data[0]), 1);
    endtask

    task automatic t_width();
        set_cfg(5, 0, 0, 50, 6);
        clear_caps();
        send(5, 9'h016, 0, 0, -1, 1, 0, 6, exp_off(6, 50), 6, 4);
        check("R4 width5", int'(cap_data[0]), 'h16);
        set_cfg(9, 0, 1, 50, 6);
        clear_caps();
        send(9, 9'h1A3, 1, 0, -1, 1, 0, 6, exp_off(6, 50), 6, 4);
        check("R4 width9", int'(cap_data[0]), 'h1A3);
        set_cfg(2, 0, 0, 50, 6);
        clear_caps();
        send(5, 9'h01F, 0, 0, -1, 1, 0, 6, exp_off(6, 50), 6, 4);
        check("R4 clamp low", int'(cap_data[0]), 'h1F);
        check("R4 clamp good", int'(cap_good[0]), 1);
    endtask

    task automatic t_parity();
        set_cfg(8, 1, 0, 50, 8);
        clear_caps();
        send(8, 9'h035, 0, 1, -1, 1, 0, 8, 4, 8, 4);
        check("R6 odd ok good", int'(cap_good[0]), 1);
        check("R6 odd ok perr", pe_cnt, 0);
        set_cfg(8, 2, 0, 50, 8);
        clear_caps();
        send(8, 9'h035, 0, 2, 1, 1, 0, 8, 4, 8, 4);
        check("R7 even bad perr", pe_cnt, 1);
        check("R7 even bad good", int'(cap_good[0]), 0);
        check("R7 data kept", int'(cap_data[0]), 'h35);
        check("R7 frame delivered", cap_cnt, 1);
        set_cfg(8, 3, 0, 50, 8);
        clear_caps();
        send(8, 9'h0FF, 0, 3, 1, 1, 0, 8, 4, 8, 4);
        check("R6 zero mode rejects 1", pe_cnt, 1);
        set_cfg(8, 4, 0, 50, 8);
        clear_caps();
        send(8, 9'h0FF, 0, 4, -1, 1, 0, 8, 4, 8, 4);
        check("R6 one mode accepts 1", int'(cap_good[0]), 1);
        set_cfg(8, 5, 0, 50, 8);
        clear_caps();
        send(8, 9'h012, 0, 5, 1, 1, 0, 8, 4, 8, 4);
        check("R6 ignore mode", int'(cap_good[0]) * 10 + pe_cnt, 10);
        check("R6 ignore data", int'(cap_data[0]), 'h12);
    endtask

    task automatic t_start_err();
        set_cfg(8, 0, 0, 50, 8);
        clear_caps();
        drive(1'b0);
        for (int j = 0; j < 20; j++) drive(1'b1);
        check("R8 start err", se_cnt, 1);
        check("R8 frame", cap_cnt, 1);
        check("R8 good", int'(cap_good[0]), 0);
        check("R8 data", int'(cap_data[0]), 0);
        clear_caps();
        send(8, 9'h05A, 0, 0, -1, 1, 0, 8, 4, 8, 4);
        check("R8 rearm data", int'(cap_data[0]), 'h5A);
    endtask

    task automatic t_stop_err();
        set_cfg(8, 0, 0, 50, 8);
        clear_caps();
        send(8, 9'h077, 0, 0, -1, 0, 0, 8, 4, 8, 0);
        for (int j = 0; j < 8; j++) drive(1'b1);
        check("R9 stop err", ste_cnt, 1);
        check("R9 good", int'(cap_good[0]), 0);
        check("R9 data", int'(cap_data[0]), 'h77);
        check("R9 single frame", cap_cnt, 1);
    endtask

    task automatic t_sample_point();
        set_cfg(8, 0, 0, 20, 10);
        clear_caps();
        send(8, 9'h0B4, 0, 0, -1, 1, 1, 10, exp_off(10, 20), 10, 4);
        check("R2 narrow pct20", int'(cap_data[0]), 'hB4);
        check("R2 narrow pct20 good", int'(cap_good[0]), 1);
        set_cfg(8, 2, 0, 99, 10);
        clear_caps();
        send(8, 9'h06D, 0, 2, -1, 1, 1, 10, exp_off(10, 99), 10, 4);
        check("R2 narrow pct99", int'(cap_data[0]), 'h6D);
        set_cfg(8, 0, 0, 0, 10);
        clear_caps();
        send(8, 9'h039, 0, 0, -1, 1, 1, 10, exp_off(10, 0), 10, 4);
        check("R3 pct0 fallback", int'(cap_data[0]), 'h39);
        set_cfg(8, 0, 0, 120, 10);
        clear_caps();
        send(8, 9'h0C6, 0, 0, -1, 1, 1, 10, exp_off(10, 120), 10, 4);
        check("R3 pct120 fallback", int'(cap_data[0]), 'hC6);
        check("R3 fallback good", int'(cap_good[0]), 1);
    endtask

    task automatic t_invert();
        set_cfg(8, 0, 0, 50, 8);
        @(negedge clk);
        rx_inv = 1'b1; rx_line = 1'b0;
        clear_caps();
        send(8, 9'h0E1, 0, 0, -1, 1, 0, 8, 4, 8, 4);
        check("R10 inverted data", int'(cap_data[0]), 'hE1);
        check("R10 inverted good", int'(cap_good[0]), 1);
        @(negedge clk);
        rx_inv = 1'b0; rx_line = 1'b1;
        drive(1'b1);
    endtask

    task automatic t_back_to_back();
        set_cfg(8, 0, 0, 50, 8);
        clear_caps();
        send(8, 9'h0F0, 0, 0, -1, 1, 0, 8, 4, 5, 0);
        send(8, 9'h00F, 0, 0, -1, 1, 0, 8, 4, 8, 4);
        check("R11 two frames", cap_cnt, 2);
        check("R11 first", int'(cap_data[0]), 'hF0);
        check("R11 second", int'(cap_data[1]), 'h0F);
    endtask

    task automatic t_cfg_hold();
        set_cfg(8, 0, 0, 50, 8);
        clear_caps();
        fork
            send(8, 9'h0A9, 0, 0, -1, 1, 0, 8, 4, 8, 4);
            begin
                repeat (6) @(negedge clk);
                cfg_width = 4'd5; cfg_msb = 1'b1; cfg_pct = 7'd10;
                cfg_cyc = 16'd20; cfg_par = 3'd1;
            end
        join
        check("R12 frame count", cap_cnt, 1);
        check("R12 data", int'(cap_data[0]), 'hA9);
        check("R12 good", int'(cap_good[0]), 1);
        set_cfg(8, 0, 0, 50, 8);
    endtask

    initial begin
        #(200_000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_basic();
        t_order();
        t_width();
        t_parity();
        t_start_err();
        t_stop_err();
        t_sample_point();
        t_invert();
        t_back_to_back();
        t_cfg_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule